// File: doc/BRIEF.md
# Diffracting Counting Tree

This block hands out unique, gap-free integer indices to a stream of requests that may arrive several per cycle. Each request is a token carrying a caller tag. Tokens enter on a single multi-lane input and descend a binary tree of balancers. Each balancer has two children, and each child is a balancer of the same kind covering half of the output wires. After log2 of the width levels, a token reaches one of `LEAVES` output wires. Each wire owns a local counter that steps by `LEAVES`, so wire j issues j, j+LEAVES, j+2·LEAVES, and so on.

A balancer does not send every token through its toggle bit. Tokens that reach a node in the same cycle are first paired in ascending lane order. The first token of a pair goes up and the second goes down, and the toggle stays as it is. Only an unpaired token reads the toggle and then inverts it. Under heavy load most tokens are diffracted this way, so the single toggle at the root stops being a serial bottleneck. The tree still has the counting property: once the tree is quiescent, the issued values form one contiguous range starting at zero.

Each tree level is one pipeline stage, and the leaf counters add one more. A token therefore appears on its own lane of exactly one output wire a fixed number of cycles after it enters, together with its tag and its index.

Top module: `dct_tree`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every `out_valid` bit is low. Reset clears every toggle to 0 and sets the next value of output wire j to j, so the first token after reset is issued 0.
- R2: At a balancer, an unpaired token goes to the upper child when the toggle is 0 and to the lower child when it is 1, and the toggle then inverts. An unpaired token is the last valid lane, in ascending lane order, when the count of tokens arriving that cycle is odd. Bit d of the output wire number is the decision taken at tree level d: 0 means upper and 1 means lower, and level 0 is the root.
- R3: Tokens that reach a balancer in the same cycle are paired in ascending lane order. The lower-lane token of each pair goes to the upper child and the other goes to the lower child, and a pair leaves the toggle unchanged.
- R4: Output wire j issues j, j+LEAVES, j+2·LEAVES and so on, in order. Tokens that reach wire j in the same cycle take successive values in ascending lane order.
- R5: A token accepted on lane l at the clock edge of cycle c appears with its tag on lane l of exactly one output wire. It appears log2(LEAVES)+1 edges later.
- R6: Once the tree is quiescent, the indices issued since reset are exactly 0..N-1 with no duplicate, where N is the number of tokens accepted since reset. At every cycle, the running per-wire issue counts are non-increasing in wire number, and wire 0 is at most one ahead of the last wire.
- R7: A lane whose `in_valid` bit is low is ignored: its tag produces no output and changes no toggle or leaf counter.
- R8: Any pattern of 1 to LANES valid lanes is accepted every cycle, back to back, with no stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | LANES (4) | One bit per input lane; a high bit presents a token |
| in_tag | input | LANES*TAG_W (32) | Tag of each lane; lane l uses bits [l*TAG_W +: TAG_W] |
| out_valid | output | LEAVES*LANES (32) | Bit j*LANES+l: a token leaves on wire j, lane l |
| out_tag | output | LEAVES*LANES*TAG_W (256) | Tag of the token in slot j*LANES+l |
| out_idx | output | LEAVES*LANES*IDX_W (512) | Index issued to the token in slot j*LANES+l |

## Verification
The bench builds the tree with four output wires, four lanes, 8-bit tags and 16-bit indices. That gives three balancers in two levels and a latency of three cycles. A full four-token burst is diffracted completely at both levels, while three-token and single-token cycles exercise the toggle at the root and at each second-level node. Because a first-level child never receives more than two tokens per cycle at this size, the per-lane index offsets inside one wire are exercised only as the single-token case.

// File: rtl/dct_pkg.sv
package dct_pkg;

   // true when n is a power of two and at least two
   function automatic bit width_ok(input int n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/dct_prism_node.sv
module dct_prism_node #(
   parameter int LANES = 4,
   parameter int TAG_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [LANES-1:0]       i_vld,
   input  logic [LANES*TAG_W-1:0] i_tag,
   output logic [LANES-1:0]       up_vld,
   output logic [LANES-1:0]       dn_vld,
   output logic [LANES*TAG_W-1:0] o_tag
);

   logic             toggle_q;
   logic             solo;
   logic [LANES-1:0] to_dn;

   if (LANES == 1) begin : g_plain
      // single lane: no partner can exist, every token uses the toggle
      always_comb begin
         solo  = i_vld[0];
         to_dn = i_vld & {LANES{toggle_q}};
      end
   end else begin : g_prism
      localparam int CW = $clog2(LANES + 1);
      logic [CW-1:0] n_in;
      logic [CW-1:0] rank;
      always_comb begin
         n_in = '0;
         for (int l = 0; l < LANES; l++) n_in = n_in + CW'(i_vld[l]);
         solo  = n_in[0];
         rank  = '0;
         to_dn = '0;
         for (int l = 0; l < LANES; l++) begin
            if (i_vld[l]) begin
               if (rank[0])                        to_dn[l] = 1'b1;     // second of a pair
               else if ((rank + CW'(1)) == n_in)   to_dn[l] = toggle_q; // unpaired leftover
               rank = rank + CW'(1);
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         toggle_q <= 1'b0;
         up_vld   <= '0;
         dn_vld   <= '0;
         o_tag    <= '0;
      end else begin
         toggle_q <= toggle_q ^ solo;
         up_vld   <= i_vld & ~to_dn;
         dn_vld   <= to_dn;
         o_tag    <= i_tag;
      end
   end

endmodule

// File: rtl/dct_leaf_issue.sv
module dct_leaf_issue #(
   parameter int LANES  = 4,
   parameter int TAG_W  = 8,
   parameter int IDX_W  = 16,
   parameter int LEAVES = 8,
   parameter int SLOT   = 0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [LANES-1:0]       i_vld,
   input  logic [LANES*TAG_W-1:0] i_tag,
   output logic [LANES-1:0]       o_vld,
   output logic [LANES*TAG_W-1:0] o_tag,
   output logic [LANES*IDX_W-1:0] o_idx
);

   localparam logic [IDX_W-1:0] STRIDE = IDX_W'(LEAVES);
   localparam logic [IDX_W-1:0] FIRST  = IDX_W'(SLOT);

   logic [IDX_W-1:0] base_q;
   logic [IDX_W-1:0] step;
   logic [IDX_W-1:0] idx_c [LANES];

   always_comb begin
      step = '0;
      for (int l = 0; l < LANES; l++) begin
         idx_c[l] = base_q + step;
         if (i_vld[l]) step = step + STRIDE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= FIRST;
         o_vld  <= '0;
         o_tag  <= '0;
         o_idx  <= '0;
      end else begin
         base_q <= base_q + step;
         o_vld  <= i_vld;
         o_tag  <= i_tag;
         for (int l = 0; l < LANES; l++) o_idx[l*IDX_W +: IDX_W] <= idx_c[l];
      end
   end

endmodule

// File: rtl/dct_tree.sv
module dct_tree #(
   parameter int LEAVES = 8,
   parameter int LANES  = 4,
   parameter int TAG_W  = 8,
   parameter int IDX_W  = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [LANES-1:0]              in_valid,
   input  logic [LANES*TAG_W-1:0]        in_tag,
   output logic [LEAVES*LANES-1:0]       out_valid,
   output logic [LEAVES*LANES*TAG_W-1:0] out_tag,
   output logic [LEAVES*LANES*IDX_W-1:0] out_idx
);

   localparam int LVLS  = $clog2(LEAVES);
   localparam int NODES = 2 * LEAVES;

   initial begin
      assert (dct_pkg::width_ok(LEAVES))
         else $error("dct_tree: LEAVES must be a power of two, at least 2");
      assert (LANES >= 1 && TAG_W >= 1)
         else $error("dct_tree: LANES and TAG_W must be positive");
      assert (IDX_W > LVLS)
         else $error("dct_tree: IDX_W too narrow for LEAVES");
   end

   // heap numbering: node (d,p) is (1<<d)+p; upper child (d+1,p), lower child (d+1,p+(1<<d))
   logic [LANES-1:0]       nv [1:NODES-1];
   logic [LANES*TAG_W-1:0] nt [1:NODES-1];

   assign nv[1] = in_valid;
   assign nt[1] = in_tag;

   for (genvar d = 0; d < LVLS; d++) begin : g_lvl
      for (genvar p = 0; p < (1 << d); p++) begin : g_node
         localparam int ND = (1 << d) + p;
         localparam int UP = ND + (1 << d);
         localparam int DN = ND + (2 << d);
         dct_prism_node #(.LANES(LANES), .TAG_W(TAG_W)) u_node (
            .clk    (clk),
            .rst_n  (rst_n),
            .i_vld  (nv[ND]),
            .i_tag  (nt[ND]),
            .up_vld (nv[UP]),
            .dn_vld (nv[DN]),
            .o_tag  (nt[UP])
         );
         assign nt[DN] = nt[UP];
      end
   end

   for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
      dct_leaf_issue #(
         .LANES (LANES), .TAG_W (TAG_W), .IDX_W (IDX_W),
         .LEAVES(LEAVES), .SLOT (j)
      ) u_leaf (
         .clk   (clk),
         .rst_n (rst_n),
         .i_vld (nv[LEAVES + j]),
         .i_tag (nt[LEAVES + j]),
         .o_vld (out_valid[j*LANES +: LANES]),
         .o_tag (out_tag[j*LANES*TAG_W +: LANES*TAG_W]),
         .o_idx (out_idx[j*LANES*IDX_W +: LANES*IDX_W])
      );
   end

endmodule

// File: rtl/dct_tree_chk.sv
module dct_tree_chk #(
   parameter int LEAVES = 8,
   parameter int LANES  = 4,
   parameter int IDX_W  = 16
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [LANES-1:0]              in_valid,
   input logic [LEAVES*LANES-1:0]       out_valid,
   input logic [LEAVES*LANES*IDX_W-1:0] out_idx
);

   localparam int LVLS = $clog2(LEAVES);
   localparam int LAT  = LVLS + 1;

   logic [LANES-1:0] dly_q [LAT];
   int               lane_cnt [LANES];
   logic [31:0]      wire_cnt_q [LEAVES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < LAT; i++) dly_q[i] <= '0;
         for (int j = 0; j < LEAVES; j++) wire_cnt_q[j] <= '0;
      end else begin
         dly_q[0] <= in_valid;
         for (int i = 1; i < LAT; i++) dly_q[i] <= dly_q[i-1];
         for (int j = 0; j < LEAVES; j++)
            wire_cnt_q[j] <= wire_cnt_q[j] + 32'($countones(out_valid[j*LANES +: LANES]));
      end
   end

   always_comb begin
      for (int l = 0; l < LANES; l++) begin
         lane_cnt[l] = 0;
         for (int j = 0; j < LEAVES; j++) lane_cnt[l] = lane_cnt[l] + int'(out_valid[j*LANES+l]);
      end
   end

   assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |=> out_valid == '0);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assert_lane_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
         dly_q[LAT-1][l] |-> lane_cnt[l] == 1);
      assert_idle_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
         !dly_q[LAT-1][l] |-> lane_cnt[l] == 0);
   end

   for (genvar j = 0; j < LEAVES; j++) begin : g_wire
      for (genvar l = 0; l < LANES; l++) begin : g_slot
         assert_wire_residue_R4: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[j*LANES+l] |->
               (out_idx[(j*LANES+l)*IDX_W +: IDX_W] % IDX_W'(LEAVES)) == IDX_W'(j));
      end
   end

   for (genvar j = 0; j + 1 < LEAVES; j++) begin : g_step
      assert_step_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (wire_cnt_q[j] >= wire_cnt_q[j+1]) && (wire_cnt_q[0] <= wire_cnt_q[LEAVES-1] + 32'd1));
   end

endmodule

bind dct_tree dct_tree_chk #(.LEAVES(LEAVES), .LANES(LANES), .IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .out_idx   (out_idx)
);

// File: tb/dct_tree_tb.sv
module dct_tree_tb;

   localparam int W   = 4;
   localparam int LN  = 4;
   localparam int TW  = 8;
   localparam int IW  = 16;
   localparam int LV  = $clog2(W);
   localparam int LAT = LV + 1;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic [LN-1:0]          in_valid = '0;
   logic [LN*TW-1:0]       in_tag = '0;
   logic [W*LN-1:0]        out_valid;
   logic [W*LN*TW-1:0]     out_tag;
   logic [W*LN*IW-1:0]     out_idx;

   always #2 clk = ~clk;   // 250 MHz

   dct_tree #(.LEAVES(W), .LANES(LN), .TAG_W(TW), .IDX_W(IW)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
      .out_valid(out_valid), .out_tag(out_tag), .out_idx(out_idx)
   );

   typedef struct {
      int tag; int lane; int leaf; int idx; int cyc;
   } exp_t;

   exp_t exp_q [$];
   bit   issued [int];
   int   got_idx [int];
   bit   tgl [1:W-1];
   int   base [W];
   int   n_chk = 0, n_bad = 0, cyc = 0;
   int   n_toggle = 0, n_diff = 0, n_sent = 0, next_tag = 0, n_out = 0;
   bit   done = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   task automatic model_reset();
      for (int n = 1; n < W; n++) tgl[n] = 1'b0;
      for (int j = 0; j < W; j++) base[j] = j;
      issued.delete();
      n_sent = 0;
   endtask

   // monitor: scoreboard lookup by tag
   always @(negedge clk) begin
      int tg, ix, pos;
      if (rst_n) begin
         for (int j = 0; j < W; j++) begin
            for (int l = 0; l < LN; l++) begin
               if (out_valid[j*LN+l]) begin
                  tg  = int'(out_tag[(j*LN+l)*TW +: TW]);
                  ix  = int'(out_idx[(j*LN+l)*IW +: IW]);
                  pos = -1;
                  n_out++;
                  foreach (exp_q[k]) if (pos < 0 && exp_q[k].tag == tg) pos = k;
                  if (pos < 0) check(1'b0, "R7", "output with no matching token, tag", tg, -1);
                  else begin
                     check(ix == exp_q[pos].idx,  "R4", "issued index", ix, exp_q[pos].idx);
                     check(j  == exp_q[pos].leaf, "R2", "output wire", j, exp_q[pos].leaf);
                     check(l  == exp_q[pos].lane, "R5", "output lane", l, exp_q[pos].lane);
                     check(cyc == exp_q[pos].cyc, "R5", "arrival cycle", cyc, exp_q[pos].cyc);
                     exp_q.delete(pos);
                  end
                  check(!issued.exists(ix), "R6", "duplicate index", ix, -1);
                  issued[ix] = 1'b1;
                  got_idx[tg] = ix;
               end
            end
         end
      end
   end

   task automatic idle_cycle();
      @(negedge clk);
      in_valid = '0;
      in_tag   = {LN{8'hA5}};   // junk on invalid lanes
   endtask

   task automatic send(input logic [LN-1:0] v);
      logic [LN-1:0] m [1:2*W-1];
      int tags [LN];
      int d, c, r;
      @(negedge clk);
      for (int l = 0; l < LN; l++) begin
         if (v[l]) begin
            tags[l] = next_tag % 256;
            next_tag++;
            n_sent++;
         end else tags[l] = 8'h5A;
         in_tag[l*TW +: TW] = TW'(tags[l]);
      end
      in_valid = v;
      // reference routing from the requirements
      for (int n = 1; n < 2*W; n++) m[n] = '0;
      m[1] = v;
      for (int nd = 1; nd < W; nd++) begin
         d = 0;
         while ((2 << d) <= nd) d++;
         c = $countones(m[nd]);
         r = 0;
         for (int l = 0; l < LN; l++) begin
            if (m[nd][l]) begin
               if (r % 2 == 0 && r == c - 1) begin
                  n_toggle++;
                  if (tgl[nd]) m[nd + (2 << d)][l] = 1'b1;
                  else         m[nd + (1 << d)][l] = 1'b1;
                  tgl[nd] = !tgl[nd];
               end else begin
                  n_diff++;
                  if (r % 2 == 1) m[nd + (2 << d)][l] = 1'b1;
                  else            m[nd + (1 << d)][l] = 1'b1;
               end
               r++;
            end
         end
      end
      for (int j = 0; j < W; j++) begin
         r = 0;
         for (int l = 0; l < LN; l++) begin
            if (m[W + j][l]) begin
               exp_q.push_back('{tag: tags[l], lane: l, leaf: j, idx: base[j] + r*W, cyc: cyc + LAT});
               r++;
            end
         end
         base[j] = base[j] + r*W;
      end
   endtask

   function automatic int got(input int tg);
      if (got_idx.exists(tg)) return got_idx[tg];
      return -1;
   endfunction

   task automatic quiesce_check(input string req);
      int miss;
      repeat (LAT + 3) idle_cycle();
      check(exp_q.size() == 0, "R5", "tokens still pending", exp_q.size(), 0);
      check(issued.size() == n_sent, req, "issued count", issued.size(), n_sent);
      miss = 0;
      for (int i = 0; i < n_sent; i++) if (!issued.exists(i)) miss++;
      check(miss == 0, "R6", "missing indices in 0..N-1", miss, 0);
      $display("quiescent: %0d tokens, %0d toggle uses, %0d diffracted", n_sent, n_toggle, n_diff);
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst_n    = 1'b0;
      in_valid = '0;
      model_reset();
      repeat (3) @(negedge clk);
      check(out_valid == '0, "R1", "out_valid during reset", int'(out_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == '0, "R1", "out_valid after reset", int'(out_valid), 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      check(1'b0, "R5", "watchdog expired at cycle", cyc, 0);
      summary();
   end

   initial begin
      int t0, n0;
      model_reset();
      apply_reset();

      // R3: a pair at the root, lanes 1 and 3; R2: a following solo token
      t0 = next_tag;
      send(4'b1010);
      send(4'b0001);
      idle_cycle();
      repeat (LAT + 2) idle_cycle();
      check(got(t0)     == 0, "R3", "first of pair (lane 1)", got(t0), 0);
      check(got(t0 + 1) == 1, "R3", "second of pair (lane 3)", got(t0 + 1), 1);
      check(got(t0 + 2) == 2, "R2", "solo after pair, root toggle untouched", got(t0 + 2), 2);

      // R7: junk tags on invalid lanes leave state alone
      repeat (6) idle_cycle();
      send(4'b0100);
      idle_cycle();
      repeat (LAT + 2) idle_cycle();
      check(got(t0 + 3) == 3, "R7", "index after ignored lanes", got(t0 + 3), 3);
      quiesce_check("R6");

      // mixed bursts of varying size with gaps
      for (int i = 0; i < 300; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (lfsr[5:4] == 2'b00) idle_cycle();
         else send(lfsr[3:0]);
      end
      quiesce_check("R6");

      // R8: back to back full cycles, then single-lane round robin
      apply_reset();
      n0 = n_out;
      for (int i = 0; i < 60; i++) send(4'b1111);
      for (int i = 0; i < 40; i++) send(LN'(1) << (i % LN));
      for (int i = 0; i < 30; i++) send((i % 2 == 0) ? 4'b0111 : 4'b1110);
      repeat (LAT + 3) idle_cycle();
      check(n_out - n0 == n_sent, "R8", "tokens returned without stall", n_out - n0, n_sent);
      quiesce_check("R6");

      summary();
   end

endmodule